// File: doc/BRIEF.md
# Input-Change Alert Unit with Alert-Response Handling

This block watches a byte of already-synchronized I/O pin levels and tells a bus host when one of them has changed. Each pin passes through its own glitch filter. A new level is accepted only after it has been sampled on a parameterized number of consecutive clock edges. An accepted change on a pin is counted as an event only when that pin is configured as an input and its per-bit interrupt enable is set. An event sets that pin's bit in a sticky status byte and marks an alert as pending. The active-low, open-drain alert line is modelled as a pull-down enable, and it is driven only while the global interrupt enable is high.

The host releases the alert in one of two ways. The first is to read the status byte: the serial interface then pulses a strobe that clears the whole status byte together with the pending alert. The second is the SMBus alert-response protocol. The serial interface hands each received address byte to the block. When that byte holds the 7-bit alert-response address 0001100 with the read bit set, and this device is currently pulling the alert line, the block reports a hit and returns its own slave address followed by a trailing bit. It then releases the line but keeps the status byte. An event accepted on the same edge as either clear is not lost: it survives the clear and keeps the alert pending.

Top module: `chg_alert`

## Requirements
- R1: After reset `alert_oe`, `status` and `ara_hit` are 0. The first sample after reset is taken as each pin's starting level and never counts as a change, whatever level the pins hold.
- R2: A level change on a pin is accepted only on the edge where the new level has been sampled on FILT_CYCLES consecutive edges (default 3). A pulse that lasts fewer edges sets no status bit.
- R3: An accepted change on pin i sets `status[i]` only when `dir_out[i]` is 0 (input) and `bit_ie[i]` is 1. Changes on other pins leave `status` and `alert_oe` unchanged.
- R4: `alert_oe` (1 = alert line pulled low) is 1 exactly when an alert is pending and `glob_ie` is 1. While `glob_ie` is 0, events still set `status`, and the pending alert shows as soon as `glob_ie` goes to 1.
- R5: A one-cycle `stat_rd` clears all of `status` and the pending alert on the next edge. An event accepted on that same edge stays set in `status` and keeps the alert pending.
- R6: A `hdr_stb` with `hdr_byte` = 8'h19 (address 0001100 in bits 7:1, read bit 1 in bit 0) while `alert_oe` is 1 gives `ara_hit` = 1 for one cycle after the edge. On that cycle `ara_resp` = {`dev_addr`, 1'b0}. The pending alert is cleared and `status` is kept.
- R7: `ara_hit` stays 0 for a header whose address differs from 0001100, for a header whose bit 0 is 0 (write), or while `alert_oe` is 0. Such a header leaves `alert_oe` and `status` unchanged.
- R8: Both rising and falling accepted changes are events. `status` and `alert_oe` change on the FILT_CYCLES-th edge after the new level first appears, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_sync | input | WIDTH | Synchronized pin levels |
| dir_out | input | WIDTH | Per-pin direction, 1 = output |
| bit_ie | input | WIDTH | Per-pin interrupt enable |
| glob_ie | input | 1 | Global interrupt enable, gates the alert line |
| dev_addr | input | 7 | This device's 7-bit slave address |
| stat_rd | input | 1 | One-cycle strobe: host read of the status byte |
| hdr_stb | input | 1 | One-cycle strobe: address byte received |
| hdr_byte | input | 8 | Received address byte, bit 0 = read |
| alert_oe | output | 1 | Pull-down enable of the open-drain alert line |
| status | output | WIDTH | Sticky per-pin change status |
| ara_hit | output | 1 | One-cycle pulse: alert-response address claimed |
| ara_resp | output | 8 | Byte to return on a hit: own address and trailing bit |

## Verification
The assertions check on every cycle that the alert line stays released while the global enable is low, that no status bit rises for a pin that is an output or has its interrupt disabled, and that a response hit happens only after a header strobe while the line was pulled low and always carries the device's own address. The glitch filter's exact acceptance edge, the survival of an event that collides with a status read, and the refusal of write or foreign headers involve timing across several cycles. Those behaviours are shown only by the bench's sweeps over every pin, configuration, polarity and pulse length, and by its directed collision and response scenarios.

// File: rtl/chg_alert_pkg.sv
package chg_alert_pkg;
   localparam int unsigned SLV_AW = 7;
   localparam logic [SLV_AW-1:0] RESP_ADDR = 7'b0001100;

   function automatic logic is_resp_read(input logic [7:0] hdr);
      return (hdr[7:1] == RESP_ADDR) && hdr[0];
   endfunction
endpackage

// File: rtl/chg_alert_filt.sv
module chg_alert_filt #(
   parameter int unsigned FILT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic chg
);
   logic prime_q;
   logic lvl_q;

   generate
      if (FILT_CYCLES == 1) begin : g_direct
         assign chg = prime_q && (pin != lvl_q);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prime_q <= 1'b0;
               lvl_q   <= 1'b0;
            end else begin
               prime_q <= 1'b1;
               lvl_q   <= pin;
            end
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);
         logic [CW-1:0] cnt_q;

         assign chg = prime_q && (pin != lvl_q) && (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prime_q <= 1'b0;
               lvl_q   <= 1'b0;
               cnt_q   <= '0;
            end else if (!prime_q) begin
               prime_q <= 1'b1;
               lvl_q   <= pin;
               cnt_q   <= '0;
            end else if (pin == lvl_q) begin
               cnt_q   <= '0;
            end else if (chg) begin
               lvl_q   <= pin;
               cnt_q   <= '0;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/chg_alert_stat.sv
module chg_alert_stat #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             stat_rd,
   input  logic             resp_clr,
   output logic [WIDTH-1:0] status,
   output logic             pend
);
   logic [WIDTH-1:0] status_q;
   logic             pend_q;
   logic             any_evt;

   assign any_evt = |evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         pend_q   <= 1'b0;
      end else begin
         status_q <= stat_rd ? evt : (status_q | evt);
         pend_q   <= (stat_rd || resp_clr) ? any_evt : (pend_q || any_evt);
      end
   end

   assign status = status_q;
   assign pend   = pend_q;
endmodule

// File: rtl/chg_alert_ara.sv
module chg_alert_ara
   import chg_alert_pkg::*;
#(
   parameter logic RESP_TAIL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_stb,
   input  logic [7:0]        hdr_byte,
   input  logic              alert_on,
   input  logic [SLV_AW-1:0] dev_addr,
   output logic              resp_clr,
   output logic              hit,
   output logic [7:0]        resp
);
   logic       hit_q;
   logic [7:0] resp_q;

   assign resp_clr = hdr_stb && alert_on && is_resp_read(hdr_byte);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         resp_q <= '0;
      end else begin
         hit_q <= resp_clr;
         if (resp_clr) resp_q <= {dev_addr, RESP_TAIL};
      end
   end

   assign hit  = hit_q;
   assign resp = resp_q;
endmodule

// File: rtl/chg_alert.sv
module chg_alert
   import chg_alert_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned FILT_CYCLES = 3,
   parameter logic        RESP_TAIL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  pin_sync,
   input  logic [WIDTH-1:0]  dir_out,
   input  logic [WIDTH-1:0]  bit_ie,
   input  logic              glob_ie,
   input  logic [SLV_AW-1:0] dev_addr,
   input  logic              stat_rd,
   input  logic              hdr_stb,
   input  logic [7:0]        hdr_byte,
   output logic              alert_oe,
   output logic [WIDTH-1:0]  status,
   output logic              ara_hit,
   output logic [7:0]        ara_resp
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("chg_alert: WIDTH must be at least 1");
      end
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("chg_alert: FILT_CYCLES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chg;
   logic [WIDTH-1:0] evt;
   logic             pend;
   logic             resp_clr;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         chg_alert_filt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_sync[i]),
            .chg   (chg[i])
         );
      end
   endgenerate

   assign evt = chg & ~dir_out & bit_ie;

   chg_alert_stat #(.WIDTH(WIDTH)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .stat_rd  (stat_rd),
      .resp_clr (resp_clr),
      .status   (status),
      .pend     (pend)
   );

   assign alert_oe = pend && glob_ie;

   chg_alert_ara #(.RESP_TAIL(RESP_TAIL)) u_ara (
      .clk      (clk),
      .rst_n    (rst_n),
      .hdr_stb  (hdr_stb),
      .hdr_byte (hdr_byte),
      .alert_on (alert_oe),
      .dev_addr (dev_addr),
      .resp_clr (resp_clr),
      .hit      (ara_hit),
      .resp     (ara_resp)
   );
endmodule

// File: rtl/chg_alert_chk.sv
module chg_alert_chk #(
   parameter int unsigned WIDTH     = 8,
   parameter logic        RESP_TAIL = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] dir_out,
   input logic [WIDTH-1:0] bit_ie,
   input logic             glob_ie,
   input logic [6:0]       dev_addr,
   input logic             hdr_stb,
   input logic             alert_oe,
   input logic [WIDTH-1:0] status,
   input logic             ara_hit,
   input logic [7:0]       ara_resp
);
   // R4
   glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_ie |-> !alert_oe);

   // R3
   qual_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & ($past(dir_out) | ~$past(bit_ie))) == '0);

   // R7
   hit_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ara_hit |-> ($past(alert_oe) && $past(hdr_stb)));

   // R6
   resp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ara_hit |-> (ara_resp == {$past(dev_addr), RESP_TAIL}));

   // R6
   hit_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ara_hit |-> (status == $past(status) || $countones(status) >= $countones($past(status))));
endmodule

bind chg_alert chg_alert_chk #(.WIDTH(WIDTH), .RESP_TAIL(RESP_TAIL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dir_out  (dir_out),
   .bit_ie   (bit_ie),
   .glob_ie  (glob_ie),
   .dev_addr (dev_addr),
   .hdr_stb  (hdr_stb),
   .alert_oe (alert_oe),
   .status   (status),
   .ara_hit  (ara_hit),
   .ara_resp (ara_resp)
);

// File: tb/test_chg_alert.sv
module test_chg_alert;
   localparam int W    = 8;
   localparam int FILT = 3;
   localparam logic [6:0] DEV = 7'h27;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pin_sync = '0;
   logic [W-1:0] dir_out = '0;
   logic [W-1:0] bit_ie = '0;
   logic         glob_ie = 1'b0;
   logic [6:0]   dev_addr = DEV;
   logic         stat_rd = 1'b0;
   logic         hdr_stb = 1'b0;
   logic [7:0]   hdr_byte = '0;
   logic         alert_oe;
   logic [W-1:0] status;
   logic         ara_hit;
   logic [7:0]   ara_resp;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   chg_alert #(.WIDTH(W), .FILT_CYCLES(FILT)) i_chg_alert (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_out(dir_out),
      .bit_ie(bit_ie), .glob_ie(glob_ie), .dev_addr(dev_addr),
      .stat_rd(stat_rd), .hdr_stb(hdr_stb), .hdr_byte(hdr_byte),
      .alert_oe(alert_oe), .status(status), .ara_hit(ara_hit),
      .ara_resp(ara_resp)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd_status();
      stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
   endtask

   task automatic send_hdr(input logic [7:0] b);
      hdr_byte = b; hdr_stb = 1'b1; tick(1); hdr_stb = 1'b0;
   endtask

   initial begin
      int lens[4];
      logic [W-1:0] exp;
      lens = '{1, FILT-1, FILT, FILT+2};

      // R1: reset state, nonzero pins at reset are not a change
      pin_sync = 8'hA5; bit_ie = '1; glob_ie = 1'b1;
      tick(3);
      chk(alert_oe, 0, "R1 alert in reset");
      chk(status, 0, "R1 status in reset");
      chk(ara_hit, 0, "R1 hit in reset");
      rst_n = 1'b1;
      tick(FILT+3);
      chk(status, 0, "R1 initial level not an event");
      chk(alert_oe, 0, "R1 alert after reset");
      pin_sync = '0; tick(FILT+2); rd_status();

      // R2 R3 R8: sweep of pin, config, polarity and pulse length
      for (int p = 0; p < 2; p++) begin
         bit_ie = '0; dir_out = '0;
         pin_sync = {W{p[0]}}; tick(FILT+3); rd_status();
         for (int b = 0; b < W; b++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
               for (int li = 0; li < 4; li++) begin
                  dir_out = cfg[0] ? (W'(1) << b) : '0;
                  bit_ie  = cfg[1] ? (W'(1) << b) : '0;
                  glob_ie = 1'b1;
                  pin_sync[b] = ~p[0];
                  tick(lens[li]);
                  pin_sync[b] = p[0];
                  tick(FILT+2);
                  exp = (!cfg[0] && cfg[1] && lens[li] >= FILT) ? (W'(1) << b) : '0;
                  chk(status, exp, "R2/R3/R8 status after pulse");
                  chk(alert_oe, exp != 0, "R3 alert after pulse");
                  rd_status();
                  chk({alert_oe, status}, 0, "R5 clear after read");
               end
            end
         end
      end

      // R8: exact acceptance edge, falling change
      dir_out = '0; bit_ie = '1; glob_ie = 1'b1;
      pin_sync = 8'h10; tick(FILT+3); rd_status();
      pin_sync = 8'h00;
      tick(FILT-1);
      chk(status, 0, "R8 not before FILT edges");
      chk(alert_oe, 0, "R8 alert not early");
      tick(1);
      chk(status, 8'h10, "R8 falling change accepted");
      chk(alert_oe, 1, "R8 alert on FILT-th edge");
      rd_status();

      // R4: global enable gating
      glob_ie = 1'b0;
      pin_sync = 8'h04; tick(FILT+1);
      chk(status, 8'h04, "R4 status set with glob_ie low");
      chk(alert_oe, 0, "R4 alert held off");
      glob_ie = 1'b1; #1;
      chk(alert_oe, 1, "R4 pending alert shows");
      rd_status();

      // R5: event on same edge as status read survives
      pin_sync = 8'h06; tick(FILT+1);
      chk(status, 8'h02, "R5 setup");
      pin_sync = 8'h0E;
      tick(FILT-1);
      stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
      chk(status, 8'h08, "R5 colliding event kept");
      chk(alert_oe, 1, "R5 alert stays pending");
      rd_status();
      chk(alert_oe, 0, "R5 cleared after second read");

      // R6: alert-response read while alerting
      pin_sync = 8'h0F; tick(FILT+1);
      chk(alert_oe, 1, "R6 setup alert");
      send_hdr(8'h19);
      chk(ara_hit, 1, "R6 hit");
      chk(ara_resp, {DEV, 1'b0}, "R6 response byte");
      chk(alert_oe, 0, "R6 alert released");
      chk(status, 8'h01, "R6 status kept");
      tick(1);
      chk(ara_hit, 0, "R6 hit is one cycle");

      // R7: no hit when not alerting, on write, or on other address
      send_hdr(8'h19);
      chk(ara_hit, 0, "R7 no hit without alert");
      rd_status();
      pin_sync = 8'h0D; tick(FILT+1);
      send_hdr(8'h18);
      chk(ara_hit, 0, "R7 write header ignored");
      chk(alert_oe, 1, "R7 alert kept after write header");
      send_hdr(8'h39);
      chk(ara_hit, 0, "R7 other address ignored");
      chk({alert_oe, status}, {1'b1, 8'h02}, "R7 state kept");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule